// File: doc/BRIEF.md
# Card Byte/Word Lane Steering Decoder

This block decodes host bus cycles for a 16-bit removable memory card made of 8-bit memory segments. One segment of each pair holds the even bytes and the other holds the odd bytes. Two active-low enables choose between byte and word access. The output enable and the write enable choose between a read and a write. The low address bit picks the even or odd byte in one byte mode. The top address bit(s) pick which segment pair is used. A space-select input switches between the common memory space and a separate attribute memory.

Each cycle, the block registers its decision about the sampled host signals. That decision sets:
- per-pair chip selects for the even and odd segments;
- a shared segment output enable;
- one write strobe per lane;
- the byte routing of write data onto the two internal 8-bit buses;
- the selection of read data for the 16-bit host bus;
- a separate drive enable for the low host lane and for the high host lane.

In the odd-byte byte mode, the odd byte is swapped onto the low host lane. The attribute memory holds only even bytes. Any odd-byte or high-lane data in attribute space is invalid: it reads as zero, and writes to it are dropped. A cycle that is illegal or discarded raises a one-cycle flag. All outputs except the read-data path appear one clock after the host signals are sampled. The read data follows the registered routing combinationally from the segment data.

Top module: `card_lane_steer`

## Requirements
- R1: With both card enables high (standby), no chip select, attribute select, write strobe or lane drive is asserted in the next cycle, and the host read data is 16'h0000.
- R2: Low enable low with high enable high is byte mode on the low lane. With address bit 0 = 0, only the even segment is selected and its byte appears on bits [7:0]. With address bit 0 = 1, only the odd segment is selected and its byte appears on bits [7:0]. The high lane is never driven in this mode.
- R3: Low enable high with high enable low is odd-only access. Only the odd segment is selected, its byte appears on bits [15:8], the low lane is not driven, and address bit 0 has no effect.
- R4: Both enables low is word access, with address bit 0 ignored. Both segments are selected, the even byte is on [7:0], the odd byte is on [15:8], and a word write strobes both segments.
- R5: With output enable high, neither host lane is driven, whatever the other inputs are.
- R6: The top address bit (bit 17 by default) selects the segment pair. Chip select bit i of each lane is set only for pair i, so at most one pair is selected per lane.
- R7: A write strobe reaches a lane only when write enable is low, output enable is high and that lane is in use. With output enable and write enable both low, nothing is written and the access flag pulses for exactly one cycle.
- R8: With space select low (attribute space), no segment chip select is asserted. Even-byte and word reads return the attribute byte on [7:0]. An odd-byte byte-mode read returns 8'h00 on the low lane. In a word read, the high lane reads 8'h00.
- R9: In attribute space, a write to the odd byte or to the high lane is discarded. Only the even byte of a word write reaches the attribute memory. Each such access pulses the access flag for one cycle, even if the host holds the cycle longer.
- R10: In odd-byte byte-mode writes, host bits [7:0] are routed to the odd write bus, and the even segment gets no strobe.
- R11: After reset, every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| space_attr_n | input | 1 | Low selects attribute space, high selects common space |
| en_lo_n | input | 1 | Active-low card enable, low lane |
| en_hi_n | input | 1 | Active-low card enable, high lane |
| rd_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| host_addr | input | ADDR_W | Host byte address; bit 0 picks the byte, top bits pick the pair |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (zero on undriven lanes) |
| host_lo_drive | output | 1 | Drive enable for host bits [7:0] |
| host_hi_drive | output | 1 | Drive enable for host bits [15:8] |
| seg_addr | output | SEG_AW | Byte-pair index sent to the segments and the attribute memory |
| even_cs | output | PAIRS | Even-segment chip select, one bit per pair |
| odd_cs | output | PAIRS | Odd-segment chip select, one bit per pair |
| seg_oe | output | 1 | Segment output enable |
| even_wr | output | 1 | Even-segment write strobe |
| odd_wr | output | 1 | Odd-segment write strobe |
| even_wdata | output | 8 | Write bus to even segment and attribute memory |
| odd_wdata | output | 8 | Write bus to odd segment |
| even_rdata | input | 8 | Read data from the selected even segment |
| odd_rdata | input | 8 | Read data from the selected odd segment |
| attr_cs | output | 1 | Attribute memory select |
| attr_wr | output | 1 | Attribute memory write strobe |
| attr_rdata | input | 8 | Attribute memory read data |
| access_err | output | 1 | One-cycle pulse on an illegal or discarded access |

## Verification
The hardest states to reach are the flag pulses. Each needs a malformed cycle held across more than one clock: output and write enable low together, or an attribute write that touches the odd byte. Only then does it show that the flag rises in the first cycle and drops in the second, while no strobe reaches any memory. The bench holds every cycle for two edges and samples the flag after each edge. It then reads the touched locations back through ordinary cycles, which shows that the background value is still there. The swapped odd-byte write is checked the same way: it is read back as a word, to show that the even half stayed untouched.

// File: rtl/card_steer_pkg.sv
package card_steer_pkg;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_EVEN   = 3'd1,
        ACC_ODD_LO = 3'd2,
        ACC_ODD_HI = 3'd3,
        ACC_WORD   = 3'd4
    } acc_mode_e;

    typedef enum logic [1:0] {
        XFER_IDLE  = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2,
        XFER_CLASH = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        LO_SRC_ZERO = 2'd0,
        LO_SRC_EVEN = 2'd1,
        LO_SRC_ODD  = 2'd2,
        LO_SRC_ATTR = 2'd3
    } lo_src_e;

    typedef enum logic {
        HI_SRC_ZERO = 1'b0,
        HI_SRC_ODD  = 1'b1
    } hi_src_e;

    typedef struct packed {
        logic even;
        logic odd;
        logic lo;
        logic hi;
    } lane_use_t;

endpackage

// File: rtl/steer_access_class.sv
module steer_access_class
    import card_steer_pkg::*;
(
    input  logic      en_lo_n,
    input  logic      en_hi_n,
    input  logic      rd_en_n,
    input  logic      wr_en_n,
    input  logic      a0,
    output acc_mode_e mode,
    output xfer_e     xfer,
    output lane_use_t lanes
);

    always_comb begin
        unique case ({en_hi_n, en_lo_n})
            2'b10:   mode = a0 ? ACC_ODD_LO : ACC_EVEN;
            2'b01:   mode = ACC_ODD_HI;
            2'b00:   mode = ACC_WORD;
            default: mode = ACC_NONE;
        endcase
    end

    always_comb begin
        unique case ({rd_en_n, wr_en_n})
            2'b01:   xfer = XFER_READ;
            2'b10:   xfer = XFER_WRITE;
            2'b00:   xfer = XFER_CLASH;
            default: xfer = XFER_IDLE;
        endcase
    end

    always_comb begin
        lanes.even = (mode == ACC_EVEN) || (mode == ACC_WORD);
        lanes.odd  = (mode == ACC_ODD_LO) || (mode == ACC_ODD_HI) || (mode == ACC_WORD);
        lanes.lo   = (mode == ACC_EVEN) || (mode == ACC_ODD_LO) || (mode == ACC_WORD);
        lanes.hi   = (mode == ACC_ODD_HI) || (mode == ACC_WORD);
    end

endmodule

// File: rtl/steer_bank_decode.sv
module steer_bank_decode #(
    parameter int PAIRS  = 2,
    parameter int BANK_W = 1
) (
    input  logic [BANK_W-1:0] bank_idx,
    output logic [PAIRS-1:0]  bank_hot
);

    generate
        if (PAIRS == 1) begin : g_single
            logic unused_idx;
            assign unused_idx  = ^bank_idx;
            assign bank_hot    = 1'b1;
        end else begin : g_multi
            for (genvar i = 0; i < PAIRS; i++) begin : g_pair
                assign bank_hot[i] = (bank_idx == BANK_W'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/steer_read_mux.sv
module steer_read_mux
    import card_steer_pkg::*;
(
    input  lo_src_e     lo_src,
    input  hi_src_e     hi_src,
    input  logic        lo_drive,
    input  logic        hi_drive,
    input  logic [7:0]  even_rdata,
    input  logic [7:0]  odd_rdata,
    input  logic [7:0]  attr_rdata,
    output logic [15:0] host_rdata
);

    logic [7:0] lo_byte;
    logic [7:0] hi_byte;

    always_comb begin
        unique case (lo_src)
            LO_SRC_EVEN: lo_byte = even_rdata;
            LO_SRC_ODD:  lo_byte = odd_rdata;
            LO_SRC_ATTR: lo_byte = attr_rdata;
            default:     lo_byte = 8'h00;
        endcase
        hi_byte = (hi_src == HI_SRC_ODD) ? odd_rdata : 8'h00;
        host_rdata = {hi_drive ? hi_byte : 8'h00, lo_drive ? lo_byte : 8'h00};
    end

endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
    import card_steer_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int PAIRS  = 2,
    parameter int BANK_BITS = (PAIRS > 1) ? $clog2(PAIRS) : 0,
    parameter int SEG_AW = ADDR_W - 1 - BANK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              space_attr_n,
    input  logic              en_lo_n,
    input  logic              en_hi_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              host_lo_drive,
    output logic              host_hi_drive,
    output logic [SEG_AW-1:0] seg_addr,
    output logic [PAIRS-1:0]  even_cs,
    output logic [PAIRS-1:0]  odd_cs,
    output logic              seg_oe,
    output logic              even_wr,
    output logic              odd_wr,
    output logic [7:0]        even_wdata,
    output logic [7:0]        odd_wdata,
    input  logic [7:0]        even_rdata,
    input  logic [7:0]        odd_rdata,
    output logic              attr_cs,
    output logic              attr_wr,
    input  logic [7:0]        attr_rdata,
    output logic              access_err
);

    localparam int BANK_W = (BANK_BITS > 0) ? BANK_BITS : 1;

    typedef struct packed {
        logic [PAIRS-1:0]  even_cs;
        logic [PAIRS-1:0]  odd_cs;
        logic              seg_oe;
        logic              even_wr;
        logic              odd_wr;
        logic              attr_cs;
        logic              attr_wr;
        logic              lo_drive;
        logic              hi_drive;
        lo_src_e           lo_src;
        hi_src_e           hi_src;
        logic [SEG_AW-1:0] seg_addr;
        logic [7:0]        even_wdata;
        logic [7:0]        odd_wdata;
        logic              err;
        logic              err_cond_prev;
    } steer_state_t;

    steer_state_t st_d, st_q;

    acc_mode_e        mode;
    xfer_e            xfer;
    lane_use_t        lanes;
    logic [BANK_W-1:0] bank_idx;
    logic [PAIRS-1:0]  bank_hot;
    logic              err_cond;

    steer_access_class u_class (
        .en_lo_n (en_lo_n),
        .en_hi_n (en_hi_n),
        .rd_en_n (rd_en_n),
        .wr_en_n (wr_en_n),
        .a0      (host_addr[0]),
        .mode    (mode),
        .xfer    (xfer),
        .lanes   (lanes)
    );

    generate
        if (BANK_BITS > 0) begin : g_bank_bits
            assign bank_idx = host_addr[ADDR_W-1 -: BANK_BITS];
        end else begin : g_no_bank_bits
            assign bank_idx = '0;
        end
    endgenerate

    steer_bank_decode #(
        .PAIRS  (PAIRS),
        .BANK_W (BANK_W)
    ) u_bank (
        .bank_idx (bank_idx),
        .bank_hot (bank_hot)
    );

    always_comb begin
        st_d            = '0;
        err_cond        = 1'b0;
        st_d.seg_addr   = host_addr[SEG_AW:1];
        st_d.even_wdata = host_wdata[7:0];
        st_d.odd_wdata  = (mode == ACC_ODD_LO) ? host_wdata[7:0] : host_wdata[15:8];

        if (mode != ACC_NONE) begin
            if (xfer == XFER_CLASH) begin
                err_cond = 1'b1;
            end else if (space_attr_n) begin
                st_d.even_cs = lanes.even ? bank_hot : '0;
                st_d.odd_cs  = lanes.odd  ? bank_hot : '0;
                if (xfer == XFER_READ) begin
                    st_d.seg_oe   = 1'b1;
                    st_d.lo_drive = lanes.lo;
                    st_d.hi_drive = lanes.hi;
                    if (mode == ACC_ODD_LO) begin
                        st_d.lo_src = LO_SRC_ODD;
                    end else if (lanes.even) begin
                        st_d.lo_src = LO_SRC_EVEN;
                    end
                    st_d.hi_src = lanes.hi ? HI_SRC_ODD : HI_SRC_ZERO;
                end else if (xfer == XFER_WRITE) begin
                    st_d.even_wr = lanes.even;
                    st_d.odd_wr  = lanes.odd;
                end
            end else begin
                st_d.attr_cs = 1'b1;
                if (xfer == XFER_READ) begin
                    st_d.lo_drive = lanes.lo;
                    st_d.hi_drive = lanes.hi;
                    st_d.lo_src   = lanes.even ? LO_SRC_ATTR : LO_SRC_ZERO;
                    st_d.hi_src   = HI_SRC_ZERO;
                end else if (xfer == XFER_WRITE) begin
                    st_d.attr_wr = lanes.even;
                    err_cond     = lanes.odd;
                end
            end
        end

        st_d.err_cond_prev = err_cond;
        st_d.err           = err_cond && !st_q.err_cond_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    steer_read_mux u_rmux (
        .lo_src     (st_q.lo_src),
        .hi_src     (st_q.hi_src),
        .lo_drive   (st_q.lo_drive),
        .hi_drive   (st_q.hi_drive),
        .even_rdata (even_rdata),
        .odd_rdata  (odd_rdata),
        .attr_rdata (attr_rdata),
        .host_rdata (host_rdata)
    );

    assign host_lo_drive = st_q.lo_drive;
    assign host_hi_drive = st_q.hi_drive;
    assign seg_addr      = st_q.seg_addr;
    assign even_cs       = st_q.even_cs;
    assign odd_cs        = st_q.odd_cs;
    assign seg_oe        = st_q.seg_oe;
    assign even_wr       = st_q.even_wr;
    assign odd_wr        = st_q.odd_wr;
    assign even_wdata    = st_q.even_wdata;
    assign odd_wdata     = st_q.odd_wdata;
    assign attr_cs       = st_q.attr_cs;
    assign attr_wr       = st_q.attr_wr;
    assign access_err    = st_q.err;

endmodule

// File: rtl/card_lane_steer_chk.sv
module card_lane_steer_chk #(
    parameter int PAIRS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             space_attr_n,
    input logic             en_lo_n,
    input logic             en_hi_n,
    input logic             rd_en_n,
    input logic             wr_en_n,
    input logic             host_lo_drive,
    input logic             host_hi_drive,
    input logic [PAIRS-1:0] even_cs,
    input logic [PAIRS-1:0] odd_cs,
    input logic             even_wr,
    input logic             odd_wr,
    input logic             attr_cs,
    input logic             attr_wr,
    input logic             access_err
);

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo_n && en_hi_n) |=> (even_cs == '0 && odd_cs == '0 && !attr_cs &&
                                  !even_wr && !odd_wr && !attr_wr &&
                                  !host_lo_drive && !host_hi_drive));

    // R2
    byte_mode_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lo_n && en_hi_n) |=> !host_hi_drive);

    // R3
    odd_only_high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo_n && !en_hi_n) |=> (!host_lo_drive && even_cs == '0 && !even_wr));

    // R5
    oe_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |=> (!host_lo_drive && !host_hi_drive));

    // R6
    one_pair_per_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(even_cs) && $onehot0(odd_cs));

    // R7
    strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (even_wr || odd_wr || attr_wr) |-> ($past(!wr_en_n) && $past(rd_en_n)));

    // R7
    clash_writes_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_n && !wr_en_n) |=> (!even_wr && !odd_wr && !attr_wr));

    // R7
    even_strobe_has_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        even_wr |-> (even_cs != '0));

    // R8
    attr_no_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!space_attr_n) |=> (even_cs == '0 && odd_cs == '0));

    // R9
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> !access_err);

endmodule

bind card_lane_steer card_lane_steer_chk #(.PAIRS(PAIRS)) u_steer_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .space_attr_n  (space_attr_n),
    .en_lo_n       (en_lo_n),
    .en_hi_n       (en_hi_n),
    .rd_en_n       (rd_en_n),
    .wr_en_n       (wr_en_n),
    .host_lo_drive (host_lo_drive),
    .host_hi_drive (host_hi_drive),
    .even_cs       (even_cs),
    .odd_cs        (odd_cs),
    .even_wr       (even_wr),
    .odd_wr        (odd_wr),
    .attr_cs       (attr_cs),
    .attr_wr       (attr_wr),
    .access_err    (access_err)
);

// File: tb/card_lane_steer_bench.sv
module card_lane_steer_bench;

    localparam int ADDR_W = 18;
    localparam int PAIRS  = 2;
    localparam int SEG_AW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              space_attr_n = 1'b1;
    logic              en_lo_n = 1'b1;
    logic              en_hi_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              host_lo_drive, host_hi_drive;
    logic [SEG_AW-1:0] seg_addr;
    logic [PAIRS-1:0]  even_cs, odd_cs;
    logic              seg_oe, even_wr, odd_wr, attr_cs, attr_wr, access_err;
    logic [7:0]        even_wdata, odd_wdata;
    logic [7:0]        even_rdata, odd_rdata, attr_rdata;

    logic [7:0] even_mem [PAIRS][256];
    logic [7:0] odd_mem  [PAIRS][256];
    logic [7:0] attr_mem [256];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0]      cap_rdata;
    logic             cap_lo, cap_hi, cap_ewr, cap_owr, cap_awr, cap_err1, cap_err2;
    logic [PAIRS-1:0] cap_ecs, cap_ocs;

    always #10 clk = ~clk;

    card_lane_steer #(.ADDR_W(ADDR_W), .PAIRS(PAIRS)) u_card_lane_steer (
        .clk(clk), .rst_n(rst_n), .space_attr_n(space_attr_n),
        .en_lo_n(en_lo_n), .en_hi_n(en_hi_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_lo_drive(host_lo_drive), .host_hi_drive(host_hi_drive),
        .seg_addr(seg_addr), .even_cs(even_cs), .odd_cs(odd_cs), .seg_oe(seg_oe),
        .even_wr(even_wr), .odd_wr(odd_wr), .even_wdata(even_wdata), .odd_wdata(odd_wdata),
        .even_rdata(even_rdata), .odd_rdata(odd_rdata),
        .attr_cs(attr_cs), .attr_wr(attr_wr), .attr_rdata(attr_rdata),
        .access_err(access_err)
    );

    // memory stubs
    assign even_rdata = even_mem[even_cs[1]][seg_addr[7:0]];
    assign odd_rdata  = odd_mem[odd_cs[1]][seg_addr[7:0]];
    assign attr_rdata = attr_mem[seg_addr[7:0]];

    always @(posedge clk) begin
        if (even_wr) even_mem[even_cs[1]][seg_addr[7:0]] <= even_wdata;
        if (odd_wr)  odd_mem[odd_cs[1]][seg_addr[7:0]]   <= odd_wdata;
        if (attr_wr) attr_mem[seg_addr[7:0]]             <= even_wdata;
    end

    function automatic logic [ADDR_W-1:0] mk_addr(input logic bank, input logic [7:0] idx,
                                                  input logic a0);
        return {bank, 8'h00, idx, a0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        space_attr_n = 1'b1; en_lo_n = 1'b1; en_hi_n = 1'b1;
        rd_en_n = 1'b1; wr_en_n = 1'b1;
    endtask

    // holds one host cycle for two clock edges and captures outputs after each
    task automatic run_cycle(input logic attr_n, input logic lo_n, input logic hi_n,
                             input logic oe_n, input logic we_n,
                             input logic [ADDR_W-1:0] addr, input logic [15:0] wd);
        @(negedge clk);
        space_attr_n = attr_n; en_lo_n = lo_n; en_hi_n = hi_n;
        rd_en_n = oe_n; wr_en_n = we_n; host_addr = addr; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cap_rdata = host_rdata; cap_lo = host_lo_drive; cap_hi = host_hi_drive;
        cap_ecs = even_cs; cap_ocs = odd_cs;
        cap_ewr = even_wr; cap_owr = odd_wr; cap_awr = attr_wr; cap_err1 = access_err;
        @(posedge clk);
        @(negedge clk);
        cap_err2 = access_err;
        go_idle();
    endtask

    task automatic t_reset();
        check("R11 rdata", host_rdata, 0);
        check("R11 cs", {even_cs, odd_cs}, 0);
        check("R11 strobes", {even_wr, odd_wr, attr_wr, attr_cs, seg_oe}, 0);
        check("R11 drives/err", {host_lo_drive, host_hi_drive, access_err}, 0);
    endtask

    task automatic t_word();
        run_cycle(1, 0, 0, 1, 0, mk_addr(0, 8'd5, 1'b1), 16'hB2A1);
        check("R4 word write strobes", {cap_ewr, cap_owr}, 2'b11);
        check("R4 word write no drive", {cap_lo, cap_hi}, 2'b00);
        run_cycle(1, 0, 0, 0, 1, mk_addr(0, 8'd5, 1'b0), 16'h0);
        check("R4 word read data", cap_rdata, 16'hB2A1);
        check("R4 word read drives", {cap_lo, cap_hi}, 2'b11);
    endtask

    task automatic t_byte_low();
        run_cycle(1, 0, 1, 0, 1, mk_addr(0, 8'd5, 1'b0), 16'h0);
        check("R2 even byte data", cap_rdata, 16'h00A1);
        check("R2 even byte lanes", {cap_lo, cap_hi, cap_ocs}, {2'b10, 2'b00});
        run_cycle(1, 0, 1, 0, 1, mk_addr(0, 8'd5, 1'b1), 16'h0);
        check("R2 odd byte swapped", cap_rdata, 16'h00B2);
        check("R2 odd byte lanes", {cap_lo, cap_hi, cap_ecs}, {2'b10, 2'b00});
    endtask

    task automatic t_odd_write();
        run_cycle(1, 0, 1, 1, 0, mk_addr(0, 8'd6, 1'b1), 16'h335C);
        check("R10 odd write strobes", {cap_ewr, cap_owr}, 2'b01);
        run_cycle(1, 0, 0, 0, 1, mk_addr(0, 8'd6, 1'b0), 16'h0);
        check("R10 odd write readback", cap_rdata, 16'h5CEE);
    endtask

    task automatic t_odd_only();
        run_cycle(1, 1, 0, 0, 1, mk_addr(0, 8'd5, 1'b0), 16'h0);
        check("R3 odd-only a0=0", {cap_rdata, cap_lo, cap_hi}, {16'hB200, 2'b01});
        run_cycle(1, 1, 0, 0, 1, mk_addr(0, 8'd5, 1'b1), 16'h0);
        check("R3 odd-only a0=1", {cap_rdata, cap_lo, cap_hi}, {16'hB200, 2'b01});
        check("R3 odd-only cs", {cap_ecs, cap_ocs}, {2'b00, 2'b01});
    endtask

    task automatic t_bank();
        run_cycle(1, 0, 0, 1, 0, mk_addr(1, 8'd5, 1'b0), 16'h7788);
        check("R6 pair1 cs", {cap_ecs, cap_ocs}, {2'b10, 2'b10});
        run_cycle(1, 0, 0, 0, 1, mk_addr(1, 8'd5, 1'b0), 16'h0);
        check("R6 pair1 read", cap_rdata, 16'h7788);
        run_cycle(1, 0, 0, 0, 1, mk_addr(0, 8'd5, 1'b0), 16'h0);
        check("R6 pair0 intact", cap_rdata, 16'hB2A1);
    endtask

    task automatic t_oe_high();
        run_cycle(1, 0, 0, 1, 1, mk_addr(0, 8'd5, 1'b0), 16'h0);
        check("R5 oe high no drive", {cap_rdata, cap_lo, cap_hi}, {16'h0000, 2'b00});
        check("R5 oe high no strobe", {cap_ewr, cap_owr}, 2'b00);
    endtask

    task automatic t_standby();
        run_cycle(1, 1, 1, 0, 1, mk_addr(0, 8'd5, 1'b0), 16'h0);
        check("R1 standby", {cap_rdata, cap_lo, cap_hi, cap_ecs, cap_ocs}, 0);
    endtask

    task automatic t_clash();
        run_cycle(1, 0, 0, 0, 0, mk_addr(0, 8'd7, 1'b0), 16'h1234);
        check("R7 clash no strobe", {cap_ewr, cap_owr, cap_awr}, 3'b000);
        check("R7 clash flag pulse", {cap_err1, cap_err2}, 2'b10);
        run_cycle(1, 0, 0, 0, 1, mk_addr(0, 8'd7, 1'b0), 16'h0);
        check("R7 clash wrote nothing", cap_rdata, 16'hEEEE);
    endtask

    task automatic t_attr();
        run_cycle(0, 0, 1, 1, 0, mk_addr(0, 8'd3, 1'b0), 16'h0042);
        check("R8 attr even write", {cap_awr, cap_err1, cap_ecs}, {2'b10, 2'b00});
        run_cycle(0, 0, 1, 0, 1, mk_addr(0, 8'd3, 1'b0), 16'h0);
        check("R8 attr even read", {cap_rdata, cap_lo}, {16'h0042, 1'b1});
        run_cycle(0, 0, 1, 0, 1, mk_addr(0, 8'd3, 1'b1), 16'h0);
        check("R8 attr odd byte invalid", {cap_rdata, cap_lo}, {16'h0000, 1'b1});
        run_cycle(0, 0, 0, 0, 1, mk_addr(0, 8'd3, 1'b0), 16'h0);
        check("R8 attr word read", {cap_rdata, cap_hi}, {16'h0042, 1'b1});
    endtask

    task automatic t_attr_discard();
        run_cycle(0, 0, 1, 1, 0, mk_addr(0, 8'd4, 1'b1), 16'h0099);
        check("R9 attr odd write", {cap_awr, cap_err1, cap_err2}, 3'b010);
        run_cycle(0, 0, 1, 0, 1, mk_addr(0, 8'd4, 1'b0), 16'h0);
        check("R9 attr odd discarded", cap_rdata, 16'h00EE);
        run_cycle(0, 1, 0, 1, 0, mk_addr(0, 8'd4, 1'b0), 16'h0011);
        check("R9 attr high lane write", {cap_awr, cap_err1, cap_err2}, 3'b010);
        run_cycle(0, 0, 0, 1, 0, mk_addr(0, 8'd3, 1'b0), 16'hAB55);
        check("R9 attr word write", {cap_awr, cap_err1, cap_err2}, 3'b110);
        run_cycle(0, 0, 1, 0, 1, mk_addr(0, 8'd3, 1'b0), 16'h0);
        check("R9 attr word even kept", cap_rdata, 16'h0055);
        run_cycle(1, 0, 0, 0, 1, mk_addr(0, 8'd3, 1'b0), 16'h0);
        check("R8 segments untouched by attr", cap_rdata, 16'hEEEE);
    endtask

    initial begin
        for (int b = 0; b < PAIRS; b++) begin
            for (int i = 0; i < 256; i++) begin
                even_mem[b][i] = 8'hEE;
                odd_mem[b][i]  = 8'hEE;
            end
        end
        for (int i = 0; i < 256; i++) attr_mem[i] = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word();
        t_byte_low();
        t_odd_write();
        t_odd_only();
        t_bank();
        t_oe_high();
        t_standby();
        t_clash();
        t_attr();
        t_attr_discard();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule